// File: doc/BRIEF.md
# Serial Flash Command Gate

This block is the command-acceptance core of a serial flash slave. It sits behind a mode-0 SPI pin set that has already been brought into the system clock domain. It captures the first byte of every chip-select frame as the opcode and keeps the write-enable latch and the busy (write-in-progress) flag. It also keeps a three-state power mode with a deep power-down state.

A data-modifying command is handed to a program/erase engine only when the frame is correctly sized, the write-enable latch is set, no internal cycle is running, and the part is awake. The hand-off is a one-cycle start pulse with the command code. The engine answers with a done pulse, and that pulse clears both flags.

The engine hand-off is a pulse pair, not a stream, so there is no valid/ready pair and no back-pressure. The engine must be able to accept a start whenever the busy flag is low. The status byte can be read over the serial interface at any time while the part is awake.

Top module: `flash_cmd_gate`

## Requirements
- R1: After reset the write-enable latch and the busy flag are 0, the power mode is standby (0), and no start pulse is issued.
- R2: Write-enable (0x06) sets the latch and write-disable (0x04) clears it. Each takes effect only when its frame is correctly sized and the busy flag is 0.
- R3: The modifying opcodes are 0x01 status write, 0x02 program, 0xA2 dual program, 0x32 quad program, 0x20 sector erase, 0xD8 block erase, 0xC7 chip erase and 0x42 one-time program. One of these is accepted when the latch is 1, the busy flag is 0 and the part is not in deep power-down. On acceptance the block issues a start pulse of exactly one cycle, and eng_cmd carries the opcode.
- R4: A frame is correctly sized when the number of rising SCK edges while chip select was low is a non-zero multiple of eight. Any other frame commits nothing.
- R5: An accepted command sets the busy flag together with the start pulse. A done pulse while the flag is 1 clears both the flag and the write-enable latch on the next cycle.
- R6: While the busy flag is 1, write-enable, write-disable, deep power-down and every modifying opcode are ignored. Read-status still works.
- R7: A correctly sized deep power-down frame (0xB9) puts the part into deep power-down (mode 2). In that state every opcode is ignored except a correctly sized release frame (0xAB), which returns the part to standby.
- R8: pwr_mode is 2 in deep power-down. Otherwise it is 1 (active) while chip select is low or the busy flag is 1, and 0 (standby) in all other cases.
- R9: After read-status (0x05), spi_miso shifts out the status byte MSB first, as {6'b0, latch, busy}. Each bit is presented while SCK is low. The byte repeats for as long as chip select stays low. spi_miso is 0 otherwise, and also in deep power-down.
- R10: Commands are committed only on the rising edge of chip select. No start pulse or flag change happens while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, synchronous to clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial status data out |
| eng_start | output | 1 | One-cycle start to the program/erase engine |
| eng_cmd | output | 8 | Opcode of the accepted command |
| eng_done | input | 1 | Completion pulse from the engine |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write-in-progress flag |
| pwr_mode | output | 2 | 0 standby, 1 active, 2 deep power-down |

## Verification
The in-line properties are checked on every cycle. They cover these facts:
- A start pulse lasts one cycle, appears only with chip select high, never during deep power-down or an earlier busy period, and always comes with the latch and busy set.
- A done pulse clears both flags.
- The busy state never reads as standby.
- spi_miso stays quiet while chip select is high.

Only the bench scenarios can show the rest:
- the acceptance decision for each opcode under each combination of latch, busy and frame length;
- which opcodes deep power-down ignores and which release it;
- the exact bit order and repetition of the status byte.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
  localparam int OP_W  = 8;
  localparam int IDX_W = $clog2(OP_W);

  typedef enum logic [1:0] {
    PM_STANDBY = 2'd0,
    PM_ACTIVE  = 2'd1,
    PM_DEEP    = 2'd2
  } pmode_e;

  localparam logic [OP_W-1:0] OP_WREN = 8'h06;
  localparam logic [OP_W-1:0] OP_WRDI = 8'h04;
  localparam logic [OP_W-1:0] OP_RDST = 8'h05;
  localparam logic [OP_W-1:0] OP_STWR = 8'h01;
  localparam logic [OP_W-1:0] OP_PROG = 8'h02;
  localparam logic [OP_W-1:0] OP_PRG2 = 8'hA2;
  localparam logic [OP_W-1:0] OP_PRG4 = 8'h32;
  localparam logic [OP_W-1:0] OP_ERSS = 8'h20;
  localparam logic [OP_W-1:0] OP_ERSB = 8'hD8;
  localparam logic [OP_W-1:0] OP_ERSC = 8'hC7;
  localparam logic [OP_W-1:0] OP_OTPW = 8'h42;
  localparam logic [OP_W-1:0] OP_SLEEP = 8'hB9;
  localparam logic [OP_W-1:0] OP_WAKE  = 8'hAB;

  function automatic logic is_modify(input logic [OP_W-1:0] op);
    return op inside {OP_STWR, OP_PROG, OP_PRG2, OP_PRG4,
                      OP_ERSS, OP_ERSB, OP_ERSC, OP_OTPW};
  endfunction
endpackage

// File: rtl/fg_shift.sv
module fg_shift
  import flash_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            mosi,
  input  logic [OP_W-1:0] status,
  input  logic            deep,
  output logic            cs_rise,
  output logic            framed,
  output logic [OP_W-1:0] opcode,
  output logic            miso
);
  logic             sck_q, cs_q;
  logic             sck_rise, cs_fall;
  logic [IDX_W-1:0] idx_q;
  logic             seen_q;
  logic [OP_W-2:0]  shreg_q;

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign cs_fall  = ~cs_n & cs_q;
  assign cs_rise  = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      seen_q  <= 1'b0;
      shreg_q <= '0;
      opcode  <= '0;
    end else if (cs_fall) begin
      idx_q  <= '0;
      seen_q <= 1'b0;
    end else if (sck_rise) begin
      shreg_q <= {shreg_q[OP_W-3:0], mosi};
      idx_q   <= idx_q + 1'b1;
      if (!seen_q && idx_q == IDX_W'(OP_W-1)) begin
        opcode <= {shreg_q, mosi};
        seen_q <= 1'b1;
      end
    end
  end

  assign framed = seen_q && (idx_q == '0);

  always_comb begin
    miso = 1'b0;
    if (!cs_n && seen_q && opcode == OP_RDST && !deep)
      miso = status[IDX_W'(OP_W-1) - idx_q];
  end

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import flash_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [OP_W-1:0] op,
  input  logic            deep,
  input  logic            eng_done,
  output logic            wel_q,
  output logic            wip_q,
  output logic            eng_start,
  output logic [OP_W-1:0] eng_cmd,
  output logic            enter_deep,
  output logic            leave_deep
);
  logic awake_ok, accept;

  assign awake_ok   = commit && !deep && !wip_q;
  assign accept     = awake_ok && wel_q && is_modify(op);
  assign enter_deep = awake_ok && op == OP_SLEEP;
  assign leave_deep = commit && deep && op == OP_WAKE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q     <= 1'b0;
      wip_q     <= 1'b0;
      eng_start <= 1'b0;
      eng_cmd   <= '0;
    end else begin
      eng_start <= accept;
      if (accept) begin
        eng_cmd <= op;
        wip_q   <= 1'b1;
      end else if (wip_q && eng_done) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end else if (awake_ok && op == OP_WREN) begin
        wel_q <= 1'b1;
      end else if (awake_ok && op == OP_WRDI) begin
        wel_q <= 1'b0;
      end
    end
  end

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> wel_q && wip_q);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && wip_q && !eng_start) |=> (!wip_q && !wel_q));
  // R6
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !$past(wip_q));
endmodule

// File: rtl/fg_power.sv
module fg_power
  import flash_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wip,
  input  logic       enter_deep,
  input  logic       leave_deep,
  output logic       deep_q,
  output logic [1:0] mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          deep_q <= 1'b0;
    else if (enter_deep) deep_q <= 1'b1;
    else if (leave_deep) deep_q <= 1'b0;
  end

  always_comb begin
    if (deep_q)            mode = PM_DEEP;
    else if (!cs_n || wip) mode = PM_ACTIVE;
    else                   mode = PM_STANDBY;
  end

  // R7
  deep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_q) |-> cs_n && !wip);
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_sck,
  input  logic            spi_cs_n,
  input  logic            spi_mosi,
  output logic            spi_miso,
  output logic            eng_start,
  output logic [OP_W-1:0] eng_cmd,
  input  logic            eng_done,
  output logic            wel,
  output logic            wip,
  output logic [1:0]      pwr_mode
);
  logic            cs_rise, framed, deep, enter_deep, leave_deep;
  logic [OP_W-1:0] opcode, status;

  assign status = {{(OP_W-2){1'b0}}, wel, wip};

  fg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .status(status), .deep(deep), .cs_rise(cs_rise), .framed(framed),
    .opcode(opcode), .miso(spi_miso)
  );

  fg_decide u_decide (
    .clk(clk), .rst_n(rst_n), .commit(cs_rise && framed), .op(opcode),
    .deep(deep), .eng_done(eng_done), .wel_q(wel), .wip_q(wip),
    .eng_start(eng_start), .eng_cmd(eng_cmd),
    .enter_deep(enter_deep), .leave_deep(leave_deep)
  );

  fg_power u_power (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .wip(wip),
    .enter_deep(enter_deep), .leave_deep(leave_deep),
    .deep_q(deep), .mode(pwr_mode)
  );

  // R10
  start_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> spi_cs_n);
  // R7
  deep_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == PM_DEEP) |-> !eng_start);
  // R8
  busy_not_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> pwr_mode != PM_STANDBY);
endmodule

// File: tb/flash_cmd_gate_bench.sv
module flash_cmd_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, eng_done = 1'b0;
  logic spi_miso, eng_start, wel, wip;
  logic [7:0] eng_cmd;
  logic [1:0] pwr_mode;

  int tests = 0, fails = 0, starts = 0;
  logic [7:0]  last_cmd = 8'h00;
  logic [15:0] rx = '0;

  always #2.5 clk = ~clk;

  flash_cmd_gate u_flash_cmd_gate (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .eng_start(eng_start),
    .eng_cmd(eng_cmd), .eng_done(eng_done), .wel(wel), .wip(wip),
    .pwr_mode(pwr_mode)
  );

  always @(posedge clk) if (eng_start) begin
    starts   <= starts + 1;
    last_cmd <= eng_cmd;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); spi_cs_n = 1'b0; repeat (2) @(negedge clk);
  endtask
  task automatic cs_hi();
    @(negedge clk); spi_cs_n = 1'b1; repeat (3) @(negedge clk);
  endtask
  task automatic shift_bit(input logic b);
    @(negedge clk); spi_mosi = b;
    repeat (2) @(negedge clk);
    rx = {rx[14:0], spi_miso};
    spi_sck = 1'b1;
    repeat (2) @(negedge clk);
    spi_sck = 1'b0;
  endtask
  task automatic xfer(input logic [7:0] op, input int extra);
    cs_lo();
    for (int i = 7; i >= 0; i--) shift_bit(op[i]);
    for (int i = 0; i < extra; i++) shift_bit(1'b0);
    cs_hi();
  endtask
  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // {opcode, extra bits, start expected, wel, wip, done afterwards}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {8'h06, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0},  // R2 write enable
    {8'h02, 5'd16, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 program accepted
    {8'h06, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0},  // R6 ignored while busy
    {8'h20, 5'd8,  1'b0, 1'b1, 1'b1, 1'b1},  // R6 erase ignored while busy
    {8'h20, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0},  // R3 no latch -> rejected
    {8'h06, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'h20, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0},  // R4 unframed erase
    {8'h04, 5'd5,  1'b0, 1'b1, 1'b0, 1'b0},  // R4 unframed disable
    {8'hC7, 5'd0,  1'b1, 1'b1, 1'b1, 1'b1},  // R3 chip erase
    {8'h06, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'h04, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0},  // R2 write disable
    {8'h06, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'h01, 5'd8,  1'b1, 1'b1, 1'b1, 1'b1},  // R3 status write
    {8'h06, 5'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'h32, 5'd24, 1'b1, 1'b1, 1'b1, 1'b1}   // R3 quad program
  };

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 wel", wel, 0);
    check("R1 wip", wip, 0);
    check("R1 mode", pwr_mode, 0);
    check("R1 starts", starts, 0);

    for (int v = 0; v < NV; v++) begin
      s0 = starts;
      xfer(VEC[v][16:9], int'(VEC[v][8:4]));
      check("R3 start count", starts - s0, int'(VEC[v][3]));
      if (VEC[v][3]) check("R3 eng_cmd", last_cmd, VEC[v][16:9]);
      check("R2 wel", wel, VEC[v][2]);
      check("R5 wip", wip, VEC[v][1]);
      if (VEC[v][0]) begin
        done_pulse();
        check("R5 wel cleared", wel, 0);
        check("R5 wip cleared", wip, 0);
        check("R8 standby after done", pwr_mode, 0);
      end
    end

    // R9 read status repeats with latch set
    xfer(8'h06, 0);
    xfer(8'h05, 16);
    check("R9 status x2", rx, 16'h0202);

    // R7 deep power-down entry and ignored opcodes
    xfer(8'hB9, 0);
    check("R7 mode deep", pwr_mode, 2);
    xfer(8'h04, 0);
    check("R7 disable ignored in deep", wel, 1);
    s0 = starts;
    xfer(8'h02, 8);
    check("R7 program ignored in deep", starts - s0, 0);
    xfer(8'h05, 16);
    check("R9 miso quiet in deep", rx, 0);
    cs_lo();
    check("R8 deep with cs low", pwr_mode, 2);
    cs_hi();
    xfer(8'hAB, 3);
    check("R7 unframed release", pwr_mode, 2);
    xfer(8'hAB, 0);
    check("R7 release to standby", pwr_mode, 0);

    // R10 nothing committed while chip select is low
    s0 = starts;
    cs_lo();
    check("R8 active with cs low", pwr_mode, 1);
    for (int i = 7; i >= 0; i--) shift_bit(logic'(8'h02 >> i));
    repeat (4) @(negedge clk);
    check("R10 no start before cs rise", starts - s0, 0);
    check("R10 wip unchanged", wip, 0);
    cs_hi();
    check("R10 start on cs rise", starts - s0, 1);
    check("R8 active while busy", pwr_mode, 1);
    // R6 read status allowed while busy
    xfer(8'h05, 16);
    check("R6 status while busy", rx, 16'h0303);
    xfer(8'hB9, 0);
    check("R6 sleep ignored while busy", pwr_mode, 1);
    done_pulse();
    check("R5 idle after done", pwr_mode, 0);
    xfer(8'h05, 8);
    check("R9 status after done", rx[7:0], 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule